// File: doc/BRIEF.md
# Refresh Interval and Open-Row Watchdog Timer

This block keeps time for a video memory controller. It makes sure that the memory is refreshed often enough and that no row stays open too long. Two 10-bit limits come from configuration registers outside the block. The refresh interval sets the largest number of system clocks between refreshes. The open-row limit sets the longest time the row strobe may stay asserted.

A refresh down-counter runs all the time. An open-row down-counter is armed each time the row strobe becomes active and counts while the strobe stays active. Either counter running out raises one refresh request toward the memory arbiter. The request holds until the arbiter pulses an acknowledge. Both live counter values are driven out for readback. The refresh sequencing and the strobe generation are done by neighbouring logic; this block only watches the strobe state and asks for refreshes.

Top module: `refresh_ras_timer`

## Requirements
- R1: While reset is asserted, `refreshCount` equals the effective refresh interval, `rasLowCount` equals the effective open-row limit, and `refreshReq` is 0. The effective value of a limit is the limit itself, or 1 when the limit is 0.
- R2: The refresh counter decrements by one on every clock. On a clock where it holds 1, it reaches zero: it reloads the effective refresh interval, and that is a refresh expiry.
- R3: A limit of 0 behaves exactly like a limit of 1. With a refresh interval of 0, a refresh expiry occurs on every clock. `refreshCount` never reads 0.
- R4: On the first clock where `rasActive` is sampled high after being sampled low (or after reset), the open-row counter loads the effective open-row limit.
- R5: On later clocks with `rasActive` high, the open-row counter decrements by one, down to 0, and then stays at 0. While `rasActive` is low the counter holds its value.
- R6: A decrement of the open-row counter from 1 to 0 is an open-row expiry. It happens at most once per assertion of `rasActive`.
- R7: Any expiry sets `refreshReq` on the same clock edge. `refreshReq` stays high until a clock where `reqAck` is sampled high. It clears on that clock unless another expiry occurs on it.
- R8: Expiries that arrive while a request is already pending merge into that one request. A single acknowledge clears it. An expiry on the same clock as an acknowledge leaves the request set.
- R9: `refreshCount` and `rasLowCount` always show the live values of the two counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refreshPeriod | input | 10 | Refresh interval limit in clocks |
| rasLowMax | input | 10 | Open-row time limit in clocks |
| rasActive | input | 1 | High while the row strobe is asserted |
| reqAck | input | 1 | One-clock acknowledge from the arbiter |
| refreshReq | output | 1 | Sticky refresh request |
| refreshCount | output | 10 | Live refresh counter value |
| rasLowCount | output | 10 | Live open-row counter value |

## Verification
The embedded assertions check the following on every clock:
- the refresh counter steps down by one or reloads the effective interval, and never reads zero;
- the open-row counter holds while the strobe is low and arms on a rising strobe;
- a pending request survives until it is acknowledged;
- every expiry strobe is followed by a raised request.

Some behaviour can only be shown by the bench's scenarios against its cycle model. This covers the exact cycle of each expiry for a chosen limit, and the single firing per strobe assertion. It also covers the merging of several expiries under one acknowledge, the collision of an expiry with an acknowledge, and the zero-limit cases.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

  // Strobes from the control module to the counter datapath
  typedef struct packed {
    logic refReload;  // refresh counter reaches zero: reload interval
    logic rasLoad;    // strobe just went active: arm open-row counter
    logic rasDec;     // strobe still active: count open-row time down
  } tmrStrobe_t;

endpackage

// File: rtl/refresh_timer_dp.sv
module refresh_timer_dp
  import refresh_timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] refreshPeriod,
  input  logic [CNT_W-1:0] rasLowMax,
  input  tmrStrobe_t       strobe,
  output logic             refAtOne,
  output logic             rasAtOne,
  output logic             rasAtZero,
  output logic [CNT_W-1:0] refCnt,
  output logic [CNT_W-1:0] rasCnt
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] effRef;
  logic [CNT_W-1:0] effRas;

  // A zero limit is raised to one so neither counter can stall
  assign effRef = (refreshPeriod == ZERO) ? ONE : refreshPeriod;
  assign effRas = (rasLowMax == ZERO) ? ONE : rasLowMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= effRef;
    end else if (strobe.refReload) begin
      refCnt <= effRef;
    end else begin
      refCnt <= refCnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasCnt <= effRas;
    end else if (strobe.rasLoad) begin
      rasCnt <= effRas;
    end else if (strobe.rasDec) begin
      rasCnt <= rasCnt - ONE;
    end
  end

  assign refAtOne  = (refCnt == ONE);
  assign rasAtOne  = (rasCnt == ONE);
  assign rasAtZero = (rasCnt == ZERO);

  // R3
  ref_never_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    refCnt != ZERO);

  // R2
  ref_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt > ONE) |=> (refCnt == $past(refCnt) - ONE));

  // R2
  ref_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt == ONE) |=> (refCnt == $past(effRef)));

  // R4
  ras_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rasLoad |=> (rasCnt == $past(effRas)));

endmodule

// File: rtl/refresh_timer_ctl.sv
module refresh_timer_ctl
  import refresh_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasActive,
  input  logic       reqAck,
  input  logic       refAtOne,
  input  logic       rasAtOne,
  input  logic       rasAtZero,
  output tmrStrobe_t strobe,
  output logic       refreshReq
);

  logic rasPrev;
  logic rasRise;
  logic rasExpire;
  logic anyExpire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasPrev <= 1'b0;
    end else begin
      rasPrev <= rasActive;
    end
  end

  assign rasRise = rasActive & ~rasPrev;

  always_comb begin
    strobe.refReload = refAtOne;
    strobe.rasLoad   = rasRise;
    strobe.rasDec    = rasActive & ~rasRise & ~rasAtZero;
  end

  assign rasExpire = strobe.rasDec & rasAtOne;
  assign anyExpire = strobe.refReload | rasExpire;

  // Expiry wins over a simultaneous acknowledge; later expiries merge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshReq <= 1'b0;
    end else begin
      refreshReq <= anyExpire | (refreshReq & ~reqAck);
    end
  end

  // R7
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !reqAck) |=> refreshReq);

  // R8
  expire_sets_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyExpire |=> refreshReq);

  // R5
  ras_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rasActive |-> !(strobe.rasDec || strobe.rasLoad));

  // R6
  ras_single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    rasExpire |=> !rasExpire);

endmodule

// File: rtl/refresh_ras_timer.sv
module refresh_ras_timer
  import refresh_timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] refreshPeriod,
  input  logic [CNT_W-1:0] rasLowMax,
  input  logic             rasActive,
  input  logic             reqAck,
  output logic             refreshReq,
  output logic [CNT_W-1:0] refreshCount,
  output logic [CNT_W-1:0] rasLowCount
);

  tmrStrobe_t strobe;
  logic       refAtOne;
  logic       rasAtOne;
  logic       rasAtZero;

  refresh_timer_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rasActive  (rasActive),
    .reqAck     (reqAck),
    .refAtOne   (refAtOne),
    .rasAtOne   (rasAtOne),
    .rasAtZero  (rasAtZero),
    .strobe     (strobe),
    .refreshReq (refreshReq)
  );

  refresh_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .refreshPeriod (refreshPeriod),
    .rasLowMax     (rasLowMax),
    .strobe        (strobe),
    .refAtOne      (refAtOne),
    .rasAtOne      (rasAtOne),
    .rasAtZero     (rasAtZero),
    .refCnt        (refreshCount),
    .rasCnt        (rasLowCount)
  );

endmodule

// File: tb/test_refresh_ras_timer.sv
`timescale 1ns/1ps
module test_refresh_ras_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] refreshPeriod = 10'd6;
  logic [9:0] rasLowMax = 10'd4;
  logic       rasActive = 1'b0;
  logic       reqAck = 1'b0;
  logic       refreshReq;
  logic [9:0] refreshCount;
  logic [9:0] rasLowCount;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  refresh_ras_timer i_refresh_ras_timer (
    .clk           (clk),
    .rstN          (rstN),
    .refreshPeriod (refreshPeriod),
    .rasLowMax     (rasLowMax),
    .rasActive     (rasActive),
    .reqAck        (reqAck),
    .refreshReq    (refreshReq),
    .refreshCount  (refreshCount),
    .rasLowCount   (rasLowCount)
  );

  // Scoreboard queues
  logic       qReq[$];
  logic [9:0] qRef[$];
  logic [9:0] qRas[$];
  string      qTag[$];

  // Cycle model state, built from the requirements
  logic       mReq;
  logic [9:0] mRef;
  logic [9:0] mRas;
  logic       mPrev;
  string      curTag = "R1";

  function automatic logic [9:0] eff(input logic [9:0] v);
    return (v == 10'd0) ? 10'd1 : v;
  endfunction

  task automatic compare(input string tag, input logic eReq,
                         input logic [9:0] eRef, input logic [9:0] eRas);
    checks++;
    if (refreshReq !== eReq || refreshCount !== eRef || rasLowCount !== eRas) begin
      fails++;
      $display("FAIL %s (R9 readback) at %0t: req=%0b ref=%0d ras=%0d expected req=%0b ref=%0d ras=%0d",
               tag, $time, refreshReq, refreshCount, rasLowCount, eReq, eRef, eRas);
    end
  endtask

  // Driver: apply one cycle of stimulus, advance the model, push expectation
  task automatic step(input logic ras, input logic ack);
    logic refExp;
    logic rasExp;
    logic rise;
    rasActive = ras;
    reqAck = ack;
    @(posedge clk);
    rise = ras & ~mPrev;
    refExp = (mRef == 10'd1);
    rasExp = 1'b0;
    mRef = refExp ? eff(refreshPeriod) : mRef - 10'd1;
    if (rise) begin
      mRas = eff(rasLowMax);
    end else if (ras && mRas != 10'd0) begin
      rasExp = (mRas == 10'd1);
      mRas = mRas - 10'd1;
    end
    mReq = refExp | rasExp | (mReq & ~ack);
    mPrev = ras;
    qReq.push_back(mReq);
    qRef.push_back(mRef);
    qRas.push_back(mRas);
    qTag.push_back(curTag);
    @(negedge clk);
  endtask

  // Monitor: compare results away from the active edge
  always begin
    @(posedge clk);
    #2;
    if (qTag.size() > 0) begin
      compare(qTag.pop_front(), qReq.pop_front(), qRef.pop_front(), qRas.pop_front());
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state with limits 6 and 4
    #12;
    compare("R1", 1'b0, 10'd6, 10'd4);
    refreshPeriod = 10'd0;
    rasLowMax = 10'd0;
    #1;
    // R1: limits of 0 show as 1 once reset reloads them
    rstN = 1'b1;
    #1 rstN = 1'b0;
    #1 compare("R1", 1'b0, 10'd1, 10'd1);
    refreshPeriod = 10'd6;
    rasLowMax = 10'd4;
    #1 rstN = 1'b1;
    #1 rstN = 1'b0;
    @(negedge clk);
    mReq = 1'b0; mRef = 10'd6; mRas = 10'd4; mPrev = 1'b0;
    rstN = 1'b1;

    // R2 / R7: free-running refresh count, sticky request without acknowledge
    curTag = "R2";
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
    curTag = "R7";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0);

    // R8: two expiries merged, one acknowledge, then ack on every cycle
    curTag = "R8";
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1);

    // R3: zero refresh interval gives an expiry every cycle
    curTag = "R3";
    refreshPeriod = 10'd0;
    for (int i = 0; i < 10; i++) step(1'b0, i[0]);

    // R4 / R6: long interval, open row held past its limit of 4
    refreshPeriod = 10'd1000;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    curTag = "R4";
    rasLowMax = 10'd4;
    step(1'b1, 1'b1);
    curTag = "R6";
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);

    // R5: short open row, counter holds while strobe is low
    curTag = "R5";
    step(1'b0, 1'b0);
    rasLowMax = 10'd9;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    rasLowMax = 10'd2;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    // R4: re-arm after a gap reloads the new limit
    curTag = "R4";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);

    // R3: zero open-row limit behaves as one
    curTag = "R3";
    rasLowMax = 10'd0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    @(posedge clk);
    #3;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule